// File: doc/BRIEF.md
# DDR3 PHY Per-Bank Data Offset Generator

This block produces the data offset that travels with every command handed to a DDR3 PHY command sequencer. The offset tells each byte-lane bank how many cycles after the command its data window opens. The value depends on the kind of command. A write uses the CAS write latency plus two. A read uses the bank's own calibrated read latency. A command that moves no data uses zero. Additive latency and the command slot are then added to the read and write values. The slot is not an input: reads and writes are placed in slot 0 when CWL is even and in slot 1 when CWL is odd, so the block takes the slot from the parity of CWL.

One to three banks can be in use, and each bank keeps its own calibrated read value. Until calibration reports completion, the block forwards the offsets supplied by the calibration logic unchanged. Once calibration is done, it switches to the computed values. Every offset is a 6-bit registered output that is loaded one cycle after a command strobe and holds its value between commands. Sums above 63 are clipped to 63 and set a sticky saturation flag. A separate flag warns when a calibrated read value of an active bank falls outside a window around the CAS latency.

Top module: `ddr_ofs_gen`

## Requirements
- R1: After reset, all bank offsets, the saturation flag and the warning flag are 0.
- R2: With calibration done and cmdType = 2'b01 (write), each active bank's offset, loaded on the first rising edge after the strobe, equals CWL + 2 + AL + (CWL & 1).
- R3: With calibration done and cmdType = 2'b10 (read), each active bank's offset equals that bank's calibrated read offset + AL + (CWL & 1).
- R4: With calibration done, cmdType = 2'b00 or 2'b11 (non-data) drives 0 to every bank.
- R5: Bank 0 is always active. numBanks = 2 also activates bank 1, and numBanks = 3 activates banks 1 and 2 (0 or 1 means bank 0 only). An inactive bank's offset is loaded with 0.
- R6: Before calibration is done, any strobed command loads each active bank with its calibration-stage offset unchanged, whatever the command type.
- R7: Without a strobe (cmdValid = 0), every offset holds its value even when other inputs change.
- R8: A computed read or write sum above 63 is output as 63, and the saturation flag is set and stays set until reset.
- R9: One cycle after its inputs, the warning flag is 1 when calibration is done and some active bank's calibrated read offset is below CL + 3 or above CL + 6. Otherwise it is 0. Inactive banks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdType | input | 2 | 00/11 non-data, 01 write, 10 read |
| calibDone | input | 1 | Calibration complete |
| numBanks | input | 2 | Number of banks in use (1 to 3) |
| cwl | input | 5 | CAS write latency |
| addLat | input | 5 | Additive latency |
| casLat | input | 5 | CAS read latency, used for the plausibility window |
| calRdOfs | input | 18 | Calibrated read offset per bank, 6 bits each, bank b at [b] |
| calPhaseOfs | input | 18 | Calibration-stage offset per bank, 6 bits each |
| bankOfs | output | 18 | Registered data offset per bank, 6 bits each |
| rdOfsWarn | output | 1 | Implausible calibrated read offset warning |
| satSticky | output | 1 | Sticky saturation flag |

## Verification
A wrong mode selection, such as staying in pass-through after calibration or picking the write term for a read, shows up as a wrong bank offset on the edge right after the strobe. A slot taken from the wrong CWL parity gives an error of exactly one that only odd CWL exposes, so both parities are applied for reads and for writes. A wrong bank-activity decode shows as a nonzero offset on an unused bank, or as a warning raised by an unused bank. A lost saturation state shows on the flag at any later cycle, because the flag is sticky.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_WR   = 2'b01,
    CMD_RD   = 2'b10,
    CMD_ALT  = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture new offsets
    logic selPass;  // forward calibration-stage offsets
    logic selWr;    // write formula
    logic selRd;    // read formula
    logic slotOdd;  // slot 1 when CWL is odd
  } ofs_strb_t;
endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
#(
  parameter int NB     = 3,
  parameter int LAT_W  = 5,
  parameter int BCNT_W = 2
) (
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic              calibDone,
  input  logic [BCNT_W-1:0] numBanks,
  input  logic [LAT_W-1:0]  cwl,
  output ofs_strb_t         strb,
  output logic [NB-1:0]     bankAct
);
  always_comb begin
    strb.loadEn  = cmdValid;
    strb.selPass = !calibDone;
    strb.selWr   = calibDone && (cmd_e'(cmdType) == CMD_WR);
    strb.selRd   = calibDone && (cmd_e'(cmdType) == CMD_RD);
    strb.slotOdd = cwl[0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_act
    if (b == 0) begin : g_first
      assign bankAct[b] = 1'b1;
    end else begin : g_rest
      assign bankAct[b] = (numBanks > BCNT_W'(b));
    end
  end
endmodule

// File: rtl/ofs_dpath.sv
module ofs_dpath
  import ofs_pkg::*;
#(
  parameter int NB      = 3,
  parameter int OFS_W   = 6,
  parameter int LAT_W   = 5,
  parameter int WARN_LO = 3,
  parameter int WARN_HI = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ofs_strb_t                  strb,
  input  logic [NB-1:0]              bankAct,
  input  logic                       calibDone,
  input  logic [LAT_W-1:0]           cwl,
  input  logic [LAT_W-1:0]           addLat,
  input  logic [LAT_W-1:0]           casLat,
  input  logic [NB-1:0][OFS_W-1:0]   calRdOfs,
  input  logic [NB-1:0][OFS_W-1:0]   calPhaseOfs,
  output logic [NB-1:0][OFS_W-1:0]   bankOfs,
  output logic                       rdOfsWarn,
  output logic                       satSticky
);
  localparam int SUM_W = OFS_W + 2;
  localparam int MAXV  = (1 << OFS_W) - 1;

  logic [NB-1:0] ovfV;
  logic [NB-1:0] badV;
  logic [SUM_W-1:0] winLo, winHi;

  assign winLo = SUM_W'(casLat) + SUM_W'(WARN_LO);
  assign winHi = SUM_W'(casLat) + SUM_W'(WARN_HI);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [SUM_W-1:0] base, sum;
    logic [OFS_W-1:0] nxt;
    logic             ovf;

    always_comb begin
      base = strb.selWr ? (SUM_W'(cwl) + SUM_W'(2)) : SUM_W'(calRdOfs[b]);
      sum  = base + SUM_W'(strb.slotOdd) + SUM_W'(addLat);
      ovf  = (strb.selWr || strb.selRd) && (sum > SUM_W'(MAXV));
      if (!bankAct[b])                    nxt = '0;
      else if (strb.selPass)              nxt = calPhaseOfs[b];
      else if (strb.selWr || strb.selRd)  nxt = ovf ? OFS_W'(MAXV) : sum[OFS_W-1:0];
      else                                nxt = '0;
    end

    assign ovfV[b] = ovf && bankAct[b];
    assign badV[b] = bankAct[b] &&
                     ((SUM_W'(calRdOfs[b]) < winLo) || (SUM_W'(calRdOfs[b]) > winHi));

    always_ff @(posedge clk) begin
      if (!rstN)            bankOfs[b] <= '0;
      else if (strb.loadEn) bankOfs[b] <= nxt;
    end

    p_inactive_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadEn && !bankAct[b] |=> bankOfs[b] == '0);

    p_pass_through_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadEn && strb.selPass && bankAct[b] |=> bankOfs[b] == $past(calPhaseOfs[b]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      satSticky <= 1'b0;
      rdOfsWarn <= 1'b0;
    end else begin
      if (strb.loadEn && |ovfV) satSticky <= 1'b1;
      rdOfsWarn <= calibDone && |badV;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(bankOfs));

  p_nodata_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn && !strb.selPass && !strb.selWr && !strb.selRd |=> bankOfs == '0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    satSticky |=> satSticky);

  p_warn_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    !calibDone |=> !rdOfsWarn);
endmodule

// File: rtl/ddr_ofs_gen.sv
module ddr_ofs_gen
  import ofs_pkg::*;
#(
  parameter int NB      = 3,
  parameter int OFS_W   = 6,
  parameter int LAT_W   = 5,
  parameter int WARN_LO = 3,
  parameter int WARN_HI = 6,
  localparam int BCNT_W = $clog2(NB + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [1:0]               cmdType,
  input  logic                     calibDone,
  input  logic [BCNT_W-1:0]        numBanks,
  input  logic [LAT_W-1:0]         cwl,
  input  logic [LAT_W-1:0]         addLat,
  input  logic [LAT_W-1:0]         casLat,
  input  logic [NB-1:0][OFS_W-1:0] calRdOfs,
  input  logic [NB-1:0][OFS_W-1:0] calPhaseOfs,
  output logic [NB-1:0][OFS_W-1:0] bankOfs,
  output logic                     rdOfsWarn,
  output logic                     satSticky
);
  ofs_strb_t     strb;
  logic [NB-1:0] bankAct;

  ofs_ctrl #(.NB(NB), .LAT_W(LAT_W), .BCNT_W(BCNT_W)) u_ctrl (
    .cmdValid(cmdValid), .cmdType(cmdType), .calibDone(calibDone),
    .numBanks(numBanks), .cwl(cwl), .strb(strb), .bankAct(bankAct)
  );

  ofs_dpath #(.NB(NB), .OFS_W(OFS_W), .LAT_W(LAT_W),
              .WARN_LO(WARN_LO), .WARN_HI(WARN_HI)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .bankAct(bankAct),
    .calibDone(calibDone), .cwl(cwl), .addLat(addLat), .casLat(casLat),
    .calRdOfs(calRdOfs), .calPhaseOfs(calPhaseOfs), .bankOfs(bankOfs),
    .rdOfsWarn(rdOfsWarn), .satSticky(satSticky)
  );
endmodule

// File: tb/tb_ddr_ofs_gen.sv
module tb_ddr_ofs_gen;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN;
  logic            cmdValid;
  logic [1:0]      cmdType;
  logic            calibDone;
  logic [1:0]      numBanks;
  logic [4:0]      cwl, addLat, casLat;
  logic [2:0][5:0] calRdOfs, calPhaseOfs, bankOfs;
  logic            rdOfsWarn, satSticky;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_ofs_gen dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .calibDone(calibDone), .numBanks(numBanks), .cwl(cwl), .addLat(addLat),
    .casLat(casLat), .calRdOfs(calRdOfs), .calPhaseOfs(calPhaseOfs),
    .bankOfs(bankOfs), .rdOfsWarn(rdOfsWarn), .satSticky(satSticky)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkBanks(input string req, input int e0, input int e1, input int e2);
    chk({req, " bank0"}, int'(bankOfs[0]), e0);
    chk({req, " bank1"}, int'(bankOfs[1]), e1);
    chk({req, " bank2"}, int'(bankOfs[2]), e2);
  endtask

  // strobe for one cycle; the result is loaded on that edge, sampled at the next negedge
  task automatic issue(input logic [1:0] t);
    @(negedge clk);
    cmdType  = t;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic t_reset();
    chkBanks("R1 reset", 0, 0, 0);
    chk("R1 reset warn", int'(rdOfsWarn), 0);
    chk("R1 reset sat", int'(satSticky), 0);
  endtask

  task automatic t_precal();
    calibDone = 1'b0; numBanks = 2'd3;
    calPhaseOfs[0] = 6'd10; calPhaseOfs[1] = 6'd11; calPhaseOfs[2] = 6'd12;
    issue(2'b01);
    chkBanks("R6 pass write", 10, 11, 12);
    calPhaseOfs[0] = 6'd20; calPhaseOfs[1] = 6'd5; calPhaseOfs[2] = 6'd33;
    issue(2'b00);
    chkBanks("R6 pass nondata", 20, 5, 33);
  endtask

  task automatic t_write();
    calibDone = 1'b1; numBanks = 2'd3; addLat = 5'd0;
    cwl = 5'd6; issue(2'b01);
    chkBanks("R2 write even", 8, 8, 8);
    cwl = 5'd7; issue(2'b01);
    chkBanks("R2 write odd", 10, 10, 10);
    addLat = 5'd3; issue(2'b01);
    chkBanks("R2 write al", 13, 13, 13);
  endtask

  task automatic t_read();
    calibDone = 1'b1; numBanks = 2'd3; addLat = 5'd0;
    calRdOfs[0] = 6'd9; calRdOfs[1] = 6'd10; calRdOfs[2] = 6'd11;
    cwl = 5'd6; issue(2'b10);
    chkBanks("R3 read even", 9, 10, 11);
    cwl = 5'd7; issue(2'b10);
    chkBanks("R3 read odd", 10, 11, 12);
    addLat = 5'd2; issue(2'b10);
    chkBanks("R3 read al", 12, 13, 14);
  endtask

  task automatic t_nodata();
    issue(2'b00);
    chkBanks("R4 nondata 00", 0, 0, 0);
    issue(2'b10);
    issue(2'b11);
    chkBanks("R4 nondata 11", 0, 0, 0);
  endtask

  task automatic t_banks();
    cwl = 5'd6; addLat = 5'd0;
    numBanks = 2'd1; issue(2'b10);
    chkBanks("R5 one bank", 9, 0, 0);
    numBanks = 2'd2; issue(2'b10);
    chkBanks("R5 two banks", 9, 10, 0);
    numBanks = 2'd0; issue(2'b01);
    chkBanks("R5 zero as one", 8, 0, 0);
    numBanks = 2'd3;
  endtask

  task automatic t_hold();
    issue(2'b10);
    chkBanks("R7 setup", 9, 10, 11);
    cwl = 5'd9; calRdOfs[0] = 6'd40; cmdType = 2'b01; calibDone = 1'b0;
    repeat (3) @(negedge clk);
    chkBanks("R7 hold", 9, 10, 11);
    calibDone = 1'b1;
  endtask

  task automatic t_sat();
    chk("R8 sat before", int'(satSticky), 0);
    calRdOfs[0] = 6'd62; calRdOfs[1] = 6'd10; calRdOfs[2] = 6'd11;
    cwl = 5'd7; addLat = 5'd5;
    issue(2'b10);
    chkBanks("R8 saturate", 63, 16, 17);
    chk("R8 sat flag", int'(satSticky), 1);
    addLat = 5'd0; cwl = 5'd6;
    issue(2'b01);
    chk("R8 sat sticky", int'(satSticky), 1);
    chk("R8 after sat bank0", int'(bankOfs[0]), 8);
  endtask

  task automatic t_warn();
    calibDone = 1'b1; numBanks = 2'd3; casLat = 5'd6;
    calRdOfs[0] = 6'd10; calRdOfs[1] = 6'd9; calRdOfs[2] = 6'd12;
    @(negedge clk); @(negedge clk);
    chk("R9 in window", int'(rdOfsWarn), 0);
    calRdOfs[1] = 6'd20;
    @(negedge clk);
    chk("R9 high", int'(rdOfsWarn), 1);
    numBanks = 2'd1;
    @(negedge clk);
    chk("R9 inactive ignored", int'(rdOfsWarn), 0);
    calRdOfs[0] = 6'd8;
    @(negedge clk);
    chk("R9 low", int'(rdOfsWarn), 1);
    calibDone = 1'b0;
    @(negedge clk);
    chk("R9 before cal", int'(rdOfsWarn), 0);
    calibDone = 1'b1; numBanks = 2'd3;
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdType = 2'b00; calibDone = 1'b0;
    numBanks = 2'd3; cwl = 5'd6; addLat = 5'd0; casLat = 5'd6;
    calRdOfs = '0; calPhaseOfs = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_precal();
    t_write();
    t_read();
    t_nodata();
    t_banks();
    t_hold();
    t_warn();
    t_sat();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule